// File: doc/BRIEF.md
# Auto-Ranging Gain Controller for a Successive-Approximation Converter

This block is the control logic that sits between a user and a 12-bit successive-approximation converter fronted by a programmable gain amplifier with eight ranges. A 3-bit gain code selects the amplifier factor: code 0 = x1, 1 = x2, 2 = x5, 3 = x10, 4 = x20, 5 = x50, 6 = x100, 7 = x200. Two threshold comparators outside the block report whether the amplified signal is too large (`over_i`) or too small (`under_i`). While no conversion is running, the controller moves the gain code one step per clock toward the usable span.

When the user requests a conversion, the controller spends one mandatory ranging cycle, plus one clock for each gain step still needed. Once settled, it raises the converter's start half a clock later and freezes the gain until the converter finishes. The converter's flag is high while it works. When that flag returns low, the 12 data bits and the 3-bit gain code are registered together and held. The user sees one busy flag that rises on the start edge and falls on the capture edge, in the same way as a bare converter's completion signal.

Top module: `auto_range_ctrl`

## Requirements
- R1: While idle and `start_i` is low, each rising clock edge moves the gain code one step: down by 1 if `over_i` is high, otherwise up by 1 if `under_i` is high, otherwise unchanged.
- R2: `start_i` high at a rising edge while idle raises `busy_o` at that edge, and the gain code does not change at that edge.
- R3: The gain code never goes below 0 or above 7, and it changes by at most one per clock.
- R4: When `over_i` and `under_i` are both high, the code decrements (over-range wins).
- R5: After the start edge, the controller takes one mandatory ranging cycle plus one clock per remaining step. For d steps, `cvt_start_o` rises at the falling edge that follows the (1+d)-th rising edge after the start edge.
- R6: `cvt_start_o` is high for exactly one clock, from a falling edge to the next falling edge. It is low at every point of the first half cycle after the rising edge that enters launch.
- R7: From the launch until completion, the gain code is frozen whatever `over_i` and `under_i` do.
- R8: After the converter flag `cvt_cc_i` has been seen high, the first rising edge with it low loads `cvt_data_i` into `result_o` and the gain code into `range_o`, and lowers `busy_o`.
- R9: `result_o` and `range_o` change only at the capture edge of R8.
- R10: `start_i` is ignored while `busy_o` is high; it starts no second conversion.
- R11: Under reset, `gain_o`, `range_o`, `result_o`, `busy_o` and `cvt_start_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the launch output is timed on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | User conversion request |
| over_i | input | 1 | Amplified input above the usable span |
| under_i | input | 1 | Amplified input below the usable span |
| cvt_cc_i | input | 1 | Converter flag, high while converting |
| cvt_data_i | input | 12 | Converter result |
| gain_o | output | 3 | Gain code to the amplifier |
| cvt_start_o | output | 1 | Start pulse to the converter, half-cycle offset |
| busy_o | output | 1 | User-facing conversion-in-progress flag |
| result_o | output | 12 | Registered conversion result |
| range_o | output | 3 | Gain code registered with the result |

## Verification
The hardest situation to reach is a start that arrives while the comparators still call for several steps. Free ranging in idle normally settles the gain before any start is given. The bench lets the gain settle on one target, then moves the modelled input to a different target in the same cycle it raises start. This forces up to seven steps inside the ranging phase, and the bench then counts the rising edges until the launch. It also moves the target during conversion to show the gain stays frozen, and it drives both comparators at once at the code floor.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RANGE,
    ST_LAUNCH,
    ST_ARM,
    ST_WAIT
  } agc_state_e;

  // Next gain code for one step; over-range wins and both ends saturate.
  function automatic int code_after_step(int code, int top_code, logic over, logic under);
    if (over) return (code > 0) ? code - 1 : code;
    if (under) return (code < top_code) ? code + 1 : code;
    return code;
  endfunction

  // A step is wanted only when it would actually move the code.
  function automatic logic step_wanted(int code, int top_code, logic over, logic under);
    return code_after_step(code, top_code, over, under) != code;
  endfunction

endpackage

// File: rtl/agc_gain_stepper.sv
module agc_gain_stepper
  import agc_pkg::*;
#(
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              over,
  input  logic              under,
  output logic [GAIN_W-1:0] gain,
  output logic              step_needed
);

  localparam int TOP_CODE = (1 << GAIN_W) - 1;

  logic [GAIN_W-1:0] gain_next;

  always_comb begin
    gain_next   = GAIN_W'(code_after_step(int'(gain), TOP_CODE, over, under));
    step_needed = step_wanted(int'(gain), TOP_CODE, over, under);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain <= '0;
    end else if (step_en) begin
      gain <= gain_next;
    end
  end

endmodule

// File: rtl/agc_sequencer.sv
module agc_sequencer
  import agc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       step_needed,
  input  logic       cc,
  output agc_state_e state,
  output logic       step_en,
  output logic       launch_req,
  output logic       capture,
  output logic       busy,
  output logic       conv_phase
);

  agc_state_e state_next;

  always_comb begin
    state_next = state;
    unique case (state)
      ST_IDLE:   if (start) state_next = ST_RANGE;
      ST_RANGE:  if (!step_needed) state_next = ST_LAUNCH;
      ST_LAUNCH: state_next = ST_ARM;
      ST_ARM:    if (cc) state_next = ST_WAIT;
      ST_WAIT:   if (!cc) state_next = ST_IDLE;
      default:   state_next = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_next;
  end

  // The start edge itself does not step; every step after it costs one clock.
  assign step_en    = ((state == ST_IDLE) && !start) || (state == ST_RANGE);
  assign launch_req = (state == ST_LAUNCH);
  assign capture    = (state == ST_WAIT) && !cc;
  assign busy       = (state != ST_IDLE);
  assign conv_phase = (state == ST_LAUNCH) || (state == ST_ARM) || (state == ST_WAIT);

endmodule

// File: rtl/agc_launch_phase.sv
module agc_launch_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_req,
  output logic cvt_start
);

  // Retimed on the falling edge: the converter sees its start half a clock
  // after the controller settles.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cvt_start <= 1'b0;
    else        cvt_start <= launch_req;
  end

endmodule

// File: rtl/agc_result_reg.sv
module agc_result_reg #(
  parameter int DATA_W = 12,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] data_in,
  input  logic [GAIN_W-1:0] gain_in,
  output logic [DATA_W-1:0] result,
  output logic [GAIN_W-1:0] range_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      range_code <= '0;
    end else if (capture) begin
      result     <= data_in;
      range_code <= gain_in;
    end
  end

endmodule

// File: rtl/auto_range_ctrl.sv
module auto_range_ctrl
  import agc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              over_i,
  input  logic              under_i,
  input  logic              cvt_cc_i,
  input  logic [DATA_W-1:0] cvt_data_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              cvt_start_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic [GAIN_W-1:0] range_o
);

  agc_state_e state;
  logic       step_en;
  logic       step_needed;
  logic       launch_req;
  logic       capture;
  logic       conv_phase;

  agc_gain_stepper #(.GAIN_W(GAIN_W)) u_stepper (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .over        (over_i),
    .under       (under_i),
    .gain        (gain_o),
    .step_needed (step_needed)
  );

  agc_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_i),
    .step_needed (step_needed),
    .cc          (cvt_cc_i),
    .state       (state),
    .step_en     (step_en),
    .launch_req  (launch_req),
    .capture     (capture),
    .busy        (busy_o),
    .conv_phase  (conv_phase)
  );

  agc_launch_phase u_launch (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_req (launch_req),
    .cvt_start  (cvt_start_o)
  );

  agc_result_reg #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .data_in    (cvt_data_i),
    .gain_in    (gain_o),
    .result     (result_o),
    .range_code (range_o)
  );

endmodule

// File: rtl/auto_range_ctrl_chk.sv
module auto_range_ctrl_chk #(
  parameter int DATA_W = 12,
  parameter int GAIN_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              over_i,
  input logic              under_i,
  input logic [DATA_W-1:0] cvt_data_i,
  input logic [GAIN_W-1:0] gain_o,
  input logic              cvt_start_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] result_o,
  input logic [GAIN_W-1:0] range_o,
  input logic              step_en,
  input logic              capture,
  input logic              conv_phase
);

  localparam logic [GAIN_W-1:0] TOP = '1;

  assert_idle_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !busy_o && !over_i && under_i && gain_o != TOP) |=> (gain_o == $past(gain_o) + 1'b1));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && $stable(gain_o)));

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gain_o == $past(gain_o)) ||
              ($past(gain_o) != TOP && gain_o == $past(gain_o) + 1'b1) ||
              ($past(gain_o) != '0 && gain_o == $past(gain_o) - 1'b1)));

  assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_o == '0 && over_i) |=> (gain_o == '0));

  assert_over_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && over_i && under_i && gain_o != '0) |=> (gain_o == $past(gain_o) - 1'b1));

  assert_launch_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_start_o |-> (busy_o && conv_phase));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_phase |=> $stable(gain_o));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (!busy_o && result_o == $past(cvt_data_i) && range_o == $past(gain_o)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(result_o) && $stable(range_o)));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !capture) |=> busy_o);

endmodule

bind auto_range_ctrl auto_range_ctrl_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .over_i      (over_i),
  .under_i     (under_i),
  .cvt_data_i  (cvt_data_i),
  .gain_o      (gain_o),
  .cvt_start_o (cvt_start_o),
  .busy_o      (busy_o),
  .result_o    (result_o),
  .range_o     (range_o),
  .step_en     (step_en),
  .capture     (capture),
  .conv_phase  (conv_phase)
);

// File: tb/auto_range_ctrl_bench.sv
module auto_range_ctrl_bench;

  localparam int DATA_W = 12;
  localparam int GAIN_W = 3;
  localparam int TOPC   = (1 << GAIN_W) - 1;
  localparam int NVEC   = 6;
  // {settled target before start, target from start on, converter data}
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{2,  5, 'h123},
    '{5,  5, 'hFFF},
    '{6,  1, 'h800},
    '{0,  8, 'h001},
    '{7, -1, 'h000},
    '{3,  4, 'hABC}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              over_i = 1'b0;
  logic              under_i = 1'b0;
  logic              cvt_cc_i = 1'b0;
  logic [DATA_W-1:0] cvt_data_i = '0;
  logic [GAIN_W-1:0] gain_o;
  logic              cvt_start_o;
  logic              busy_o;
  logic [DATA_W-1:0] result_o;
  logic [GAIN_W-1:0] range_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  target  = 0;
  bit  force_both = 1'b0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  auto_range_ctrl #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_auto_range_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .over_i(over_i), .under_i(under_i),
    .cvt_cc_i(cvt_cc_i), .cvt_data_i(cvt_data_i), .gain_o(gain_o),
    .cvt_start_o(cvt_start_o), .busy_o(busy_o), .result_o(result_o), .range_o(range_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Ideal comparators: the right code is the target, clamped by the amplifier.
  task automatic update_cmp();
    if (force_both) begin
      over_i  = 1'b1;
      under_i = 1'b1;
    end else begin
      over_i  = int'(gain_o) > target;
      under_i = int'(gain_o) < target;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    update_cmp();
  endtask

  function automatic int clamp_code(int t);
    return (t < 0) ? 0 : ((t > TOPC) ? TOPC : t);
  endfunction

  initial begin
    int prev_result;
    prev_result = 0;
    #1;
    check(gain_o == 0 && busy_o == 0 && cvt_start_o == 0, "R11", "reset gain/busy/start", int'(gain_o), 0);
    check(result_o == 0 && range_o == 0, "R11", "reset result", int'(result_o), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    update_cmp();

    for (int v = 0; v < NVEC; v++) begin
      int pre, post, fin, d, lat, data, frozen;
      bit early;
      pre  = VEC[v][0];
      post = VEC[v][1];
      data = VEC[v][2];
      fin  = clamp_code(post);
      d    = (fin > pre) ? fin - pre : pre - fin;
      lat  = -1;
      early = 1'b0;

      target = pre;
      update_cmp();
      repeat (10) tick();
      check(int'(gain_o) == pre, "R1", "idle ranging settled", int'(gain_o), pre);
      check(busy_o == 0, "R1", "idle busy", int'(busy_o), 0);

      start_i = 1'b1;
      target  = post;
      update_cmp();
      for (int n = 0; n < 40; n++) begin
        @(posedge clk);
        #1;
        start_i = 1'b0;
        update_cmp();
        early = cvt_start_o;
        #2;
        if (n == 0) begin
          check(busy_o == 1, "R2", "busy after start edge", int'(busy_o), 1);
          check(int'(gain_o) == pre, "R2", "no step on start edge", int'(gain_o), pre);
        end
        if (cvt_start_o) begin
          lat = n;
          break;
        end
      end
      check(lat == 1 + d, "R5", "edges to launch", lat, 1 + d);
      check(early == 0, "R6", "launch held back half a cycle", int'(early), 0);
      check(int'(gain_o) == fin, "R3", "settled code saturated", int'(gain_o), fin);
      frozen = int'(gain_o);

      tick();
      #2;
      check(cvt_start_o == 0, "R6", "launch one clock wide", int'(cvt_start_o), 0);
      cvt_cc_i = 1'b1;
      target   = (fin + 3) % (TOPC + 1);
      start_i  = 1'b1;
      update_cmp();
      tick();
      start_i = 1'b0;
      repeat (12) tick();
      #2;
      check(int'(gain_o) == frozen, "R7", "gain frozen in conversion", int'(gain_o), frozen);
      check(busy_o == 1, "R8", "busy during conversion", int'(busy_o), 1);
      check(int'(result_o) == prev_result, "R9", "result held", int'(result_o), prev_result);

      cvt_cc_i   = 1'b0;
      cvt_data_i = DATA_W'(data);
      tick();
      #2;
      check(busy_o == 0, "R8", "busy falls at capture", int'(busy_o), 0);
      check(int'(result_o) == data, "R8", "result captured", int'(result_o), data);
      check(int'(range_o) == fin, "R8", "range captured", int'(range_o), fin);
      prev_result = data;
      cvt_data_i = '0;
      repeat (4) tick();
      #2;
      check(busy_o == 0, "R10", "start during conversion ignored", int'(busy_o), 0);
      check(int'(range_o) == fin && int'(result_o) == data, "R9", "range held after capture", int'(range_o), fin);
    end

    // Directed: priority with both comparators asserted, then floor and ceiling.
    target = 4;
    update_cmp();
    repeat (10) tick();
    force_both = 1'b1;
    update_cmp();
    tick();
    #2;
    check(int'(gain_o) == 3, "R4", "over-range wins", int'(gain_o), 3);
    repeat (6) tick();
    #2;
    check(int'(gain_o) == 0, "R3", "floor saturation", int'(gain_o), 0);
    force_both = 1'b0;
    target = 9;
    update_cmp();
    repeat (10) tick();
    #2;
    check(int'(gain_o) == TOPC, "R3", "ceiling saturation", int'(gain_o), TOPC);
    check(busy_o == 0 && cvt_start_o == 0, "R10", "no stray launch", int'(cvt_start_o), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule